// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation miss by searching a hashed page table in memory. A miss request carries a virtual page number and a segment identifier. The walker hashes them into a group index and adds the group's offset to a table base value to get the address of the first entry. It then fetches the entries of that group one at a time and stops at the first entry that matches.

If none of the eight entries in the primary group match, the walker searches a secondary group whose index is the complement of the primary one. If that group also misses, the walker reports a fault so that software can handle the miss. Memory is reached through a single-outstanding read port. Each walk ends with a one-cycle completion pulse that carries either the physical page number or a fault flag. The walker does not insert or replace entries.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_rd_valid` and `done_valid` are 0.
- R2: The primary group index is the low 6 bits of `req_vpn` XOR `req_sid`. The first read of a walk goes to word address `table_base + index*8`.
- R3: Within a group, entries are read in slot order 0 to 7. Each read address is one more than the previous read address.
- R4: Only one memory read is outstanding at a time. After a read is issued, no further read is issued until `mem_rsp_valid` has returned the data.
- R5: The entry word has these fields: bit 23 is valid, bit 22 is the group-select bit (0 for primary, 1 for secondary), bits 21:12 are the tag, and bits 11:0 are the physical page. An entry matches only if it is valid, its group-select bit equals the group being searched, and its tag equals `req_vpn[15:6]`.
- R6: The walk stops at the first matching entry. No further read is issued, and `done_ppn` carries that entry's page with `done_fault` at 0.
- R7: If all eight primary entries miss, the walker searches the secondary group. That group's index is the bitwise complement of the primary index within 6 bits, and its first read goes to `table_base + index*8`.
- R8: If all 16 entries miss, the walker completes with `done_fault` at 1 and `done_ppn` at 0, after exactly 16 reads.
- R9: While a walk is in progress, `req_ready` is 0 and `req_valid` has no effect.
- R10: `done_valid` is a single-cycle pulse. The walker is ready again in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| table_base | input | 16 | Word address of the start of the hashed table |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vpn | input | 16 | Virtual page number of the miss |
| req_sid | input | 6 | Segment identifier mixed into the hash |
| mem_rd_valid | output | 1 | Memory read request, one cycle per entry |
| mem_rd_addr | output | 16 | Word address of the entry being read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 24 | Page table entry word |
| done_valid | output | 1 | Walk completion pulse |
| done_fault | output | 1 | No translation found in either group |
| done_ppn | output | 12 | Physical page number on a hit |

## Verification
Some properties can be checked on every cycle, and the assertions do so. They check the single-outstanding read discipline, that reads within a group go to consecutive addresses, that completion is a one-cycle pulse followed by readiness, and that an accepted request drops `req_ready`.

Other behaviour only shows up in directed scenarios against a memory model, and the bench covers it. This includes the hash arithmetic and the base offset, the fall-through to the complemented secondary group, and the rejection of entries with a wrong tag, a clear valid bit or the wrong group-select bit. It also includes stopping at the first match when a later entry also matches, and the fault after sixteen misses.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    localparam int VPN_W  = 16;
    localparam int GRP_W  = 6;
    localparam int SLOT_N = 8;
    localparam int SLOT_W = $clog2(SLOT_N);
    localparam int TAG_W  = VPN_W - GRP_W;
    localparam int PPN_W  = 12;
    localparam int ADDR_W = 16;
    localparam int ENT_W  = 2 + TAG_W + PPN_W;

    typedef struct packed {
        logic             vld;
        logic             hsel;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_st_e;

    function automatic logic [GRP_W-1:0] primary_idx(
        input logic [VPN_W-1:0] vpn,
        input logic [GRP_W-1:0] sid
    );
        return vpn[GRP_W-1:0] ^ sid;
    endfunction

    function automatic logic [GRP_W-1:0] secondary_idx(
        input logic [GRP_W-1:0] prim
    );
        return ~prim;
    endfunction

    function automatic logic [TAG_W-1:0] vpn_tag(input logic [VPN_W-1:0] vpn);
        return vpn[VPN_W-1:GRP_W];
    endfunction

endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
    import hpt_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [GRP_W-1:0]  sid,
    input  logic              hsel,
    input  logic [SLOT_W-1:0] slot,
    output logic [ADDR_W-1:0] addr
);
    localparam int OFF_W = GRP_W + SLOT_W;

    logic [GRP_W-1:0] prim;
    logic [GRP_W-1:0] grp;
    logic [OFF_W-1:0] offset;

    always_comb begin
        prim   = primary_idx(vpn, sid);
        grp    = hsel ? secondary_idx(prim) : prim;
        offset = {grp, slot};
        addr   = base + ADDR_W'(offset);
    end
endmodule

// File: rtl/hpt_pte_match.sv
module hpt_pte_match
    import hpt_pkg::*;
(
    input  logic [ENT_W-1:0] word,
    input  logic [TAG_W-1:0] want_tag,
    input  logic             want_hsel,
    output logic             hit,
    output logic [PPN_W-1:0] ppn
);
    pte_t ent;

    always_comb begin
        ent = pte_t'(word);
        hit = ent.vld && (ent.hsel == want_hsel) && (ent.tag == want_tag);
        ppn = ent.ppn;
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] table_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [GRP_W-1:0]  req_sid,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              done_valid,
    output logic              done_fault,
    output logic [PPN_W-1:0]  done_ppn
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_N - 1);

    walk_st_e          state_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [GRP_W-1:0]  sid_q;
    logic              hsel_q;
    logic [SLOT_W-1:0] slot_q;
    logic              fault_q;
    logic [PPN_W-1:0]  ppn_q;
    logic              ent_hit;
    logic [PPN_W-1:0]  ent_ppn;

    hpt_addr_gen u_addr (
        .base (table_base),
        .vpn  (vpn_q),
        .sid  (sid_q),
        .hsel (hsel_q),
        .slot (slot_q),
        .addr (mem_rd_addr)
    );

    hpt_pte_match u_match (
        .word      (mem_rsp_data),
        .want_tag  (vpn_tag(vpn_q)),
        .want_hsel (hsel_q),
        .hit       (ent_hit),
        .ppn       (ent_ppn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
            sid_q   <= '0;
            hsel_q  <= 1'b0;
            slot_q  <= '0;
            fault_q <= 1'b0;
            ppn_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    vpn_q   <= req_vpn;
                    sid_q   <= req_sid;
                    hsel_q  <= 1'b0;
                    slot_q  <= '0;
                    state_q <= ST_ISSUE;
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (ent_hit) begin
                        fault_q <= 1'b0;
                        ppn_q   <= ent_ppn;
                        state_q <= ST_DONE;
                    end else if (slot_q != LAST_SLOT) begin
                        slot_q  <= slot_q + 1'b1;
                        state_q <= ST_ISSUE;
                    end else if (!hsel_q) begin
                        hsel_q  <= 1'b1;
                        slot_q  <= '0;
                        state_q <= ST_ISSUE;
                    end else begin
                        fault_q <= 1'b1;
                        ppn_q   <= '0;
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign mem_rd_valid = (state_q == ST_ISSUE);
    assign done_valid   = (state_q == ST_DONE);
    assign done_fault   = fault_q;
    assign done_ppn     = ppn_q;

    logic [ADDR_W-1:0] last_addr_q;
    always_ff @(posedge clk) begin
        if (rst) last_addr_q <= '0;
        else if (mem_rd_valid) last_addr_q <= mem_rd_addr;
    end

    // R4
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |=> !mem_rd_valid);

    // R4
    no_read_while_waiting_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !mem_rsp_valid) |=> !mem_rd_valid);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && slot_q != '0) |-> (mem_rd_addr == last_addr_q + 1'b1));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> (!done_valid && req_ready));

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    fault_ppn_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault) |-> (done_ppn == '0));
endmodule

// File: tb/hpt_walker_bench.sv
module hpt_walker_bench;
    import hpt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [ADDR_W-1:0] BASE = 16'h0100;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] table_base = BASE;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [VPN_W-1:0]  req_vpn = '0;
    logic [GRP_W-1:0]  req_sid = '0;
    logic              mem_rd_valid;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [ENT_W-1:0]  mem_rsp_data = '0;
    logic              done_valid;
    logic              done_fault;
    logic [PPN_W-1:0]  done_ppn;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpt_walker u_hpt_walker (
        .clk(clk), .rst(rst), .table_base(table_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_sid(req_sid),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_fault(done_fault), .done_ppn(done_ppn)
    );

    typedef struct {
        logic              f;
        logic [PPN_W-1:0]  p;
        int                n;
        logic [ADDR_W-1:0] a1;
        logic [ADDR_W-1:0] a2;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;

    logic [ENT_W-1:0] mem [0:1023];
    logic             p1 = 1'b0;
    logic [ENT_W-1:0] d1 = '0;

    int                rd_count = 0;
    logic [ADDR_W-1:0] first_a, sec_a, prev_a;

    task automatic chk(input string req, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [GRP_W-1:0] tb_idx(input logic [15:0] vpn, input logic [5:0] sid);
        return (vpn[5:0] ^ sid);
    endfunction

    function automatic logic [ADDR_W-1:0] grp_addr(input logic [5:0] idx);
        return BASE + 16'(idx) * 16'd8;
    endfunction

    function automatic logic [ENT_W-1:0] mk(input logic v, input logic h,
                                           input logic [9:0] t, input logic [11:0] p);
        return {v, h, t, p};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
    endtask

    // memory model and monitor
    always @(negedge clk) begin
        mem_rsp_valid = p1;
        mem_rsp_data  = d1;
        p1 = mem_rd_valid;
        d1 = mem[mem_rd_addr[9:0]];
        if (!rst && mem_rd_valid) begin
            rd_count++;
            if (rd_count == 1) first_a = mem_rd_addr;
            else if (rd_count == 9) sec_a = mem_rd_addr;
            else chk("R3 step", mem_rd_addr == prev_a + 1, mem_rd_addr, prev_a + 1);
            prev_a = mem_rd_addr;
        end
        if (!rst && done_valid) begin
            if (q.size() == 0) begin
                chk("R9 unexpected completion", 1'b0, 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R6/R8 fault", done_fault == e.f, done_fault, e.f);
                chk("R6/R8 ppn", done_ppn == e.p, done_ppn, e.p);
                chk("R6/R8 reads", rd_count == e.n, rd_count, e.n);
                chk("R2 first addr", first_a == e.a1, first_a, e.a1);
                if (e.n > 8) chk("R7 secondary addr", sec_a == e.a2, sec_a, e.a2);
            end
            rd_count = 0;
        end
    end

    task automatic launch(input logic [15:0] vpn, input logic [5:0] sid, input exp_t e);
        q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_vpn = vpn; req_sid = sid; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_empty();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk("R10 ready after done", req_ready == 1'b1, req_ready, 1);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        exp_t e;
        logic [5:0] ix, sx;
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 ready", req_ready == 1'b1, req_ready, 1);
        chk("R1 rd", mem_rd_valid == 1'b0, mem_rd_valid, 0);
        chk("R1 done", done_valid == 1'b0, done_valid, 0);

        // R2 / R6: hit at slot 0 of primary group
        ix = tb_idx(16'h1234, 6'h05);
        mem[grp_addr(ix)[9:0]] = mk(1, 0, 10'h048, 12'hABC);
        e = '{f:0, p:12'hABC, n:1, a1:grp_addr(ix), a2:'0};
        launch(16'h1234, 6'h05, e);
        wait_empty();

        // R5 / R6: wrong tag, invalid, wrong hsel skipped; stop at slot 5
        clear_mem();
        ix = tb_idx(16'hBEEF, 6'h2A);
        mem[grp_addr(ix)[9:0] + 0] = mk(1, 0, 10'h2FA, 12'h001);
        mem[grp_addr(ix)[9:0] + 1] = mk(0, 0, 10'h2FB, 12'h002);
        mem[grp_addr(ix)[9:0] + 2] = mk(1, 1, 10'h2FB, 12'h003);
        mem[grp_addr(ix)[9:0] + 5] = mk(1, 0, 10'h2FB, 12'h777);
        mem[grp_addr(ix)[9:0] + 6] = mk(1, 0, 10'h2FB, 12'h111);
        e = '{f:0, p:12'h777, n:6, a1:grp_addr(ix), a2:'0};
        launch(16'hBEEF, 6'h2A, e);
        wait_empty();

        // R7: primary misses, secondary slot 2 hits
        clear_mem();
        ix = tb_idx(16'h0F00, 6'h11);
        sx = ~ix;
        for (int i = 0; i < 8; i++) mem[grp_addr(ix)[9:0] + 10'(i)] = mk(1, 0, 10'h03D, 12'h0EE);
        mem[grp_addr(sx)[9:0] + 1] = mk(1, 0, 10'h03C, 12'h0DD);
        mem[grp_addr(sx)[9:0] + 2] = mk(1, 1, 10'h03C, 12'h5A5);
        e = '{f:0, p:12'h5A5, n:11, a1:grp_addr(ix), a2:grp_addr(sx)};
        launch(16'h0F00, 6'h11, e);
        wait_empty();

        // R8 fault, with R9 request driven while busy
        clear_mem();
        ix = tb_idx(16'h4321, 6'h00);
        sx = ~ix;
        e = '{f:1, p:12'h000, n:16, a1:grp_addr(ix), a2:grp_addr(sx)};
        launch(16'h4321, 6'h00, e);
        @(negedge clk);
        req_vpn = 16'h1234; req_sid = 6'h05; req_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 busy", req_ready == 1'b0, req_ready, 0);
        end
        req_valid = 1'b0;
        wait_empty();
        repeat (30) @(negedge clk);
        chk("R9 no extra walk", q.size() == 0 && rd_count == 0, rd_count, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule